// File: doc/BRIEF.md
# Clock Stop and Power-Down Gating Controller

This block sits behind a clock generator and decides, group by group, which of the already generated clocks reach the board. It takes a CPU-domain clock, a free-running PCI-domain clock, a reference clock and a 48 MHz clock. It drives six CPU clocks, seven stoppable PCI clocks, one PCI clock that ignores the PCI stop, two APIC clocks, three reference clocks and one 48 MHz clock. Three active-low asynchronous controls steer it: a CPU stop, a PCI stop and a power-down.

Each control is brought into the domain it governs through a two-flop synchroniser. Each output group is gated by an enable that is registered on the falling edge of its source clock and ANDed with that clock. A gated output therefore stops low only after a complete high phase, and it restarts only with a complete high phase. Power-down overrides both stop inputs and silences every output. When power-down is released, a wake timer in the reference domain holds every group off for a fixed number of reference cycles. After that, the stop inputs again decide which groups run. The timer needs a power-down pulse of at least three reference cycles and a wake count of at least 2.

Top module: `clkstop_gate`

## Requirements
- R1: Within 3 CPU clock cycles after `cpu_stop_n_i` falls, all CPU outputs stay low. The last pulse before stopping is a full high phase.
- R2: After `cpu_stop_n_i` rises, the CPU outputs resume within 3 CPU clock cycles (first rising edge on the 3rd CPU edge after the change). Every pulse from then on is a complete cycle.
- R3: `pci_stop_n_i` is sampled on rising edges of the free-running PCI clock. Within 3 PCI clock cycles after it falls, the seven stoppable PCI outputs are held at 0.
- R4: After `pci_stop_n_i` rises, the stoppable PCI outputs toggle again within 3 PCI clock cycles.
- R5: `pci_free_o` keeps toggling whatever the state of `pci_stop_n_i`.
- R6: While `pwr_dn_n_i` is low, every output is low, including `pci_free_o`. Each group stops within 3 cycles of its own source clock.
- R7: After `pwr_dn_n_i` rises, every output stays low while the wake timer counts exactly `WAKE_CYCLES` reference-clock cycles. After that, the outputs run at full rate.
- R8: Power-down takes priority over both stop inputs. Once the wake delay ends, a CPU stop that is still low keeps the CPU outputs low while the other groups run.
- R9: Every high pulse on a gated output lasts exactly one high phase of its source clock.
- R10: While `rst_n_i` is low, every output is low. After reset, the outputs start within a few cycles, with no wake delay, because reset clears the wake timer.
- R11: All outputs of one group change together and are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu_i | input | 1 | CPU-domain source clock |
| clk_pci_i | input | 1 | Free-running PCI-domain source clock |
| clk_ref_i | input | 1 | Reference source clock for the APIC and reference outputs and the wake timer |
| clk_48_i | input | 1 | 48 MHz source clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| cpu_stop_n_i | input | 1 | Asynchronous active-low CPU clock stop |
| pci_stop_n_i | input | 1 | Asynchronous active-low stop for the stoppable PCI clocks |
| pwr_dn_n_i | input | 1 | Asynchronous active-low power-down |
| cpu_clk_o | output | N_CPU (6) | Gated CPU clocks |
| pci_clk_o | output | N_PCI (7) | Gated PCI clocks, stopped by the PCI stop |
| pci_free_o | output | 1 | PCI clock that is stopped only by power-down |
| apic_clk_o | output | N_APIC (2) | Gated APIC clocks from the reference clock |
| ref_clk_o | output | N_REF (3) | Gated copies of the reference clock |
| usb_clk_o | output | 1 | Gated 48 MHz clock |

## Verification
The bench builds the block with its default group widths and `WAKE_CYCLES` set to 40. With that count, the whole wake delay after power-down, and its expiry, fit into a run of a few microseconds. The windows can then show both that the outputs stay silent for the full count and that they run again afterwards. The default group widths keep all twenty outputs in play, so every run exercises group-wide lockstep and the pulse-width checks on each clock domain.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

    // Default output counts per group
    parameter int unsigned DEF_N_CPU  = 6;
    parameter int unsigned DEF_N_PCI  = 7;
    parameter int unsigned DEF_N_APIC = 2;
    parameter int unsigned DEF_N_REF  = 3;

    // Roughly 3 ms worth of a 14.318 MHz reference
    parameter int unsigned DEF_WAKE_CYCLES = 42955;

    // Phases of the power-down wake timer
    typedef enum logic [1:0] {
        PWR_RUN  = 2'd0,
        PWR_DOWN = 2'd1,
        PWR_WAKE = 2'd2
    } pwr_state_e;

    // Gate enables that the top computes for each group
    typedef struct packed {
        logic cpu;
        logic pci;
        logic pci_free;
        logic refc;
        logic usb;
    } grp_en_t;

endpackage

// File: rtl/clkstop_sync2.sv
module clkstop_sync2 #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic d_i,
    output logic q_o
);

    logic meta_q;
    logic sync_q;

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;

endmodule

// File: rtl/clkstop_gate_grp.sv
module clkstop_gate_grp #(
    parameter int unsigned WIDTH = 1
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             en_i,
    output logic             en_q_o,
    output logic [WIDTH-1:0] clk_o
);

    logic en_q;

    // Enable moves only while the source clock is low, so the AND below
    // can neither truncate a high phase nor open in the middle of one.
    always_ff @(negedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            en_q <= 1'b0;
        end else begin
            en_q <= en_i;
        end
    end

    assign en_q_o = en_q;

    for (genvar i = 0; i < int'(WIDTH); i++) begin : g_out
        assign clk_o[i] = clk_i & en_q;
    end

endmodule

// File: rtl/clkstop_wake_timer.sv
module clkstop_wake_timer
    import clkstop_pkg::*;
#(
    parameter int unsigned WAKE_CYCLES = DEF_WAKE_CYCLES
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic pd_n_i,
    output logic hold_o
);

    localparam int unsigned CW = (WAKE_CYCLES > 2) ? $clog2(WAKE_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(WAKE_CYCLES - 1);

    typedef struct packed {
        pwr_state_e     st;
        logic [CW-1:0]  cnt;
    } tmr_t;

    tmr_t s_d;
    tmr_t s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            PWR_RUN: begin
                if (!pd_n_i) begin
                    s_d.st  = PWR_DOWN;
                    s_d.cnt = '0;
                end
            end
            PWR_DOWN: begin
                // The release edge itself is the first counted cycle
                if (pd_n_i) begin
                    s_d.st  = PWR_WAKE;
                    s_d.cnt = CW'(1);
                end
            end
            PWR_WAKE: begin
                if (!pd_n_i) begin
                    s_d.st  = PWR_DOWN;
                    s_d.cnt = '0;
                end else if (s_q.cnt == LAST) begin
                    s_d.st  = PWR_RUN;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + CW'(1);
                end
            end
            default: begin
                s_d.st  = PWR_DOWN;
                s_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            s_q.st  <= PWR_RUN;
            s_q.cnt <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign hold_o = (s_q.st != PWR_RUN);

endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate
    import clkstop_pkg::*;
#(
    parameter int unsigned N_CPU       = DEF_N_CPU,
    parameter int unsigned N_PCI       = DEF_N_PCI,
    parameter int unsigned N_APIC      = DEF_N_APIC,
    parameter int unsigned N_REF       = DEF_N_REF,
    parameter int unsigned WAKE_CYCLES = DEF_WAKE_CYCLES
) (
    input  logic              clk_cpu_i,
    input  logic              clk_pci_i,
    input  logic              clk_ref_i,
    input  logic              clk_48_i,
    input  logic              rst_n_i,
    input  logic              cpu_stop_n_i,
    input  logic              pci_stop_n_i,
    input  logic              pwr_dn_n_i,
    output logic [N_CPU-1:0]  cpu_clk_o,
    output logic [N_PCI-1:0]  pci_clk_o,
    output logic              pci_free_o,
    output logic [N_APIC-1:0] apic_clk_o,
    output logic [N_REF-1:0]  ref_clk_o,
    output logic              usb_clk_o
);

    localparam int unsigned N_RDOM = N_APIC + N_REF;

    // Synchronised controls, one set per governed domain
    logic cpu_run_s, pd_cpu_s, hold_cpu_s;
    logic pci_run_s, pd_pci_s, hold_pci_s;
    logic pd_ref_s;
    logic pd_usb_s, hold_usb_s;
    logic wake_hold;

    // Registered (falling-edge) enables from the gate groups
    logic cpu_en_q, pci_en_q, free_en_q, ref_en_q, usb_en_q;
    logic [N_RDOM-1:0] rdom_clk;

    grp_en_t en_d;

    // CPU domain: stops reset to "stopped", power-down to "running"
    clkstop_sync2 #(.RST_VAL(1'b0)) u_sy_cpu_stop (
        .clk_i(clk_cpu_i), .rst_n_i(rst_n_i), .d_i(cpu_stop_n_i), .q_o(cpu_run_s));
    clkstop_sync2 #(.RST_VAL(1'b1)) u_sy_cpu_pd (
        .clk_i(clk_cpu_i), .rst_n_i(rst_n_i), .d_i(pwr_dn_n_i), .q_o(pd_cpu_s));
    clkstop_sync2 #(.RST_VAL(1'b0)) u_sy_cpu_hold (
        .clk_i(clk_cpu_i), .rst_n_i(rst_n_i), .d_i(wake_hold), .q_o(hold_cpu_s));

    // PCI domain
    clkstop_sync2 #(.RST_VAL(1'b0)) u_sy_pci_stop (
        .clk_i(clk_pci_i), .rst_n_i(rst_n_i), .d_i(pci_stop_n_i), .q_o(pci_run_s));
    clkstop_sync2 #(.RST_VAL(1'b1)) u_sy_pci_pd (
        .clk_i(clk_pci_i), .rst_n_i(rst_n_i), .d_i(pwr_dn_n_i), .q_o(pd_pci_s));
    clkstop_sync2 #(.RST_VAL(1'b0)) u_sy_pci_hold (
        .clk_i(clk_pci_i), .rst_n_i(rst_n_i), .d_i(wake_hold), .q_o(hold_pci_s));

    // Reference domain: power-down sync feeds the wake timer
    clkstop_sync2 #(.RST_VAL(1'b1)) u_sy_ref_pd (
        .clk_i(clk_ref_i), .rst_n_i(rst_n_i), .d_i(pwr_dn_n_i), .q_o(pd_ref_s));

    clkstop_wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
        .clk_i(clk_ref_i), .rst_n_i(rst_n_i), .pd_n_i(pd_ref_s), .hold_o(wake_hold));

    // 48 MHz domain
    clkstop_sync2 #(.RST_VAL(1'b1)) u_sy_usb_pd (
        .clk_i(clk_48_i), .rst_n_i(rst_n_i), .d_i(pwr_dn_n_i), .q_o(pd_usb_s));
    clkstop_sync2 #(.RST_VAL(1'b0)) u_sy_usb_hold (
        .clk_i(clk_48_i), .rst_n_i(rst_n_i), .d_i(wake_hold), .q_o(hold_usb_s));

    // Power-down and the wake hold dominate every group
    always_comb begin
        en_d          = '0;
        en_d.cpu      = cpu_run_s & pd_cpu_s & ~hold_cpu_s;
        en_d.pci      = pci_run_s & pd_pci_s & ~hold_pci_s;
        en_d.pci_free = pd_pci_s & ~hold_pci_s;
        en_d.refc     = pd_ref_s & ~wake_hold;
        en_d.usb      = pd_usb_s & ~hold_usb_s;
    end

    clkstop_gate_grp #(.WIDTH(N_CPU)) u_g_cpu (
        .clk_i(clk_cpu_i), .rst_n_i(rst_n_i), .en_i(en_d.cpu),
        .en_q_o(cpu_en_q), .clk_o(cpu_clk_o));

    clkstop_gate_grp #(.WIDTH(N_PCI)) u_g_pci (
        .clk_i(clk_pci_i), .rst_n_i(rst_n_i), .en_i(en_d.pci),
        .en_q_o(pci_en_q), .clk_o(pci_clk_o));

    clkstop_gate_grp #(.WIDTH(1)) u_g_free (
        .clk_i(clk_pci_i), .rst_n_i(rst_n_i), .en_i(en_d.pci_free),
        .en_q_o(free_en_q), .clk_o(pci_free_o));

    clkstop_gate_grp #(.WIDTH(N_RDOM)) u_g_ref (
        .clk_i(clk_ref_i), .rst_n_i(rst_n_i), .en_i(en_d.refc),
        .en_q_o(ref_en_q), .clk_o(rdom_clk));

    clkstop_gate_grp #(.WIDTH(1)) u_g_usb (
        .clk_i(clk_48_i), .rst_n_i(rst_n_i), .en_i(en_d.usb),
        .en_q_o(usb_en_q), .clk_o(usb_clk_o));

    assign apic_clk_o = rdom_clk[N_APIC-1:0];
    assign ref_clk_o  = rdom_clk[N_RDOM-1:N_APIC];

endmodule

// File: rtl/clkstop_chk.sv
module clkstop_chk #(
    parameter int unsigned WAKE_CYCLES = 2
) (
    input logic clk_cpu_i,
    input logic clk_pci_i,
    input logic clk_ref_i,
    input logic clk_48_i,
    input logic rst_n_i,
    input logic cpu_stop_n_i,
    input logic pci_stop_n_i,
    input logic pwr_dn_n_i,
    input logic cpu_en_q,
    input logic pci_en_q,
    input logic free_en_q,
    input logic ref_en_q,
    input logic usb_en_q,
    input logic pd_cpu_s,
    input logic hold_cpu_s,
    input logic pd_pci_s,
    input logic hold_pci_s,
    input logic pd_ref_s,
    input logic wake_hold
);

    // Edges seen since reset per domain, saturating at 3
    logic [1:0] age_cpu, age_pci, age_ref, age_usb;
    logic [31:0] wake_seen;

    always_ff @(posedge clk_cpu_i or negedge rst_n_i)
        if (!rst_n_i) age_cpu <= '0; else if (age_cpu != 2'd3) age_cpu <= age_cpu + 2'd1;
    always_ff @(posedge clk_pci_i or negedge rst_n_i)
        if (!rst_n_i) age_pci <= '0; else if (age_pci != 2'd3) age_pci <= age_pci + 2'd1;
    always_ff @(posedge clk_ref_i or negedge rst_n_i)
        if (!rst_n_i) age_ref <= '0; else if (age_ref != 2'd3) age_ref <= age_ref + 2'd1;
    always_ff @(posedge clk_48_i or negedge rst_n_i)
        if (!rst_n_i) age_usb <= '0; else if (age_usb != 2'd3) age_usb <= age_usb + 2'd1;

    // Independent count of reference cycles spent holding after release
    always_ff @(posedge clk_ref_i or negedge rst_n_i) begin
        if (!rst_n_i)        wake_seen <= '0;
        else if (!pd_ref_s)  wake_seen <= '0;
        else if (wake_hold)  wake_seen <= wake_seen + 32'd1;
    end

    // R1: stop low for three samples means the CPU gate is closed
    p_cpu_stop_r1: assert property (@(posedge clk_cpu_i) disable iff (!rst_n_i)
        (age_cpu == 2'd3 && !cpu_stop_n_i && !$past(cpu_stop_n_i) && !$past(cpu_stop_n_i, 2))
        |-> !cpu_en_q);

    // R2: stop released and no power-down in force means the CPU gate is open
    p_cpu_run_r2: assert property (@(posedge clk_cpu_i) disable iff (!rst_n_i)
        (age_cpu == 2'd3 && $past(cpu_stop_n_i) && $past(cpu_stop_n_i, 2)
         && pd_cpu_s && !hold_cpu_s) |-> cpu_en_q);

    // R3: PCI stop held low closes the stoppable PCI gate
    p_pci_stop_r3: assert property (@(posedge clk_pci_i) disable iff (!rst_n_i)
        (age_pci == 2'd3 && !pci_stop_n_i && !$past(pci_stop_n_i) && !$past(pci_stop_n_i, 2))
        |-> !pci_en_q);

    // R5: the free PCI gate follows only power-down, never the PCI stop
    p_pci_free_r5: assert property (@(posedge clk_pci_i) disable iff (!rst_n_i)
        (age_pci == 2'd3 && pd_pci_s && !hold_pci_s) |-> free_en_q);

    // R6: power-down held low closes every gate in every domain
    p_pd_cpu_r6: assert property (@(posedge clk_cpu_i) disable iff (!rst_n_i)
        (age_cpu == 2'd3 && !pwr_dn_n_i && !$past(pwr_dn_n_i) && !$past(pwr_dn_n_i, 2))
        |-> !cpu_en_q);
    p_pd_pci_r6: assert property (@(posedge clk_pci_i) disable iff (!rst_n_i)
        (age_pci == 2'd3 && !pwr_dn_n_i && !$past(pwr_dn_n_i) && !$past(pwr_dn_n_i, 2))
        |-> (!pci_en_q && !free_en_q));
    p_pd_ref_r6: assert property (@(posedge clk_ref_i) disable iff (!rst_n_i)
        (age_ref == 2'd3 && !pwr_dn_n_i && !$past(pwr_dn_n_i) && !$past(pwr_dn_n_i, 2))
        |-> !ref_en_q);
    p_pd_usb_r6: assert property (@(posedge clk_48_i) disable iff (!rst_n_i)
        (age_usb == 2'd3 && !pwr_dn_n_i && !$past(pwr_dn_n_i) && !$past(pwr_dn_n_i, 2))
        |-> !usb_en_q);

    // R7: the hold ends after exactly the configured number of reference cycles
    p_wake_count_r7: assert property (@(posedge clk_ref_i) disable iff (!rst_n_i)
        $fell(wake_hold) |-> (wake_seen == WAKE_CYCLES));

    // R8: while the wake hold is in force the CPU gate stays closed regardless of its stop
    p_hold_over_stop_r8: assert property (@(posedge clk_cpu_i) disable iff (!rst_n_i)
        hold_cpu_s |-> !cpu_en_q);

endmodule

bind clkstop_gate clkstop_chk #(.WAKE_CYCLES(WAKE_CYCLES)) u_chk (
    .clk_cpu_i    (clk_cpu_i),
    .clk_pci_i    (clk_pci_i),
    .clk_ref_i    (clk_ref_i),
    .clk_48_i     (clk_48_i),
    .rst_n_i      (rst_n_i),
    .cpu_stop_n_i (cpu_stop_n_i),
    .pci_stop_n_i (pci_stop_n_i),
    .pwr_dn_n_i   (pwr_dn_n_i),
    .cpu_en_q     (cpu_en_q),
    .pci_en_q     (pci_en_q),
    .free_en_q    (free_en_q),
    .ref_en_q     (ref_en_q),
    .usb_en_q     (usb_en_q),
    .pd_cpu_s     (pd_cpu_s),
    .hold_cpu_s   (hold_cpu_s),
    .pd_pci_s     (pd_pci_s),
    .hold_pci_s   (hold_pci_s),
    .pd_ref_s     (pd_ref_s),
    .wake_hold    (wake_hold)
);

// File: tb/sim_clkstop_gate.sv
`timescale 1ns/1ps
module sim_clkstop_gate;

    localparam int unsigned WAKE = 40;
    localparam logic [15:0] ANY  = 16'hFFFF;

    logic clk_cpu = 1'b0, clk_pci = 1'b0, clk_ref = 1'b0, clk_48 = 1'b0;
    logic rst_n = 1'b1, cpu_stop_n = 1'b1, pci_stop_n = 1'b1, pwr_dn_n = 1'b1;
    logic [5:0] cpu_o;
    logic [6:0] pci_o;
    logic       free_o;
    logic [1:0] apic_o;
    logic [2:0] ref_o;
    logic       usb_o;

    always #10 clk_cpu = ~clk_cpu;   // 50 MHz
    always #15 clk_pci = ~clk_pci;
    always #35 clk_ref = ~clk_ref;
    always #11 clk_48  = ~clk_48;

    clkstop_gate #(.WAKE_CYCLES(WAKE)) u0 (
        .clk_cpu_i(clk_cpu), .clk_pci_i(clk_pci), .clk_ref_i(clk_ref), .clk_48_i(clk_48),
        .rst_n_i(rst_n), .cpu_stop_n_i(cpu_stop_n), .pci_stop_n_i(pci_stop_n),
        .pwr_dn_n_i(pwr_dn_n), .cpu_clk_o(cpu_o), .pci_clk_o(pci_o), .pci_free_o(free_o),
        .apic_clk_o(apic_o), .ref_clk_o(ref_o), .usb_clk_o(usb_o));

    int n_tests = 0, n_fail = 0, n_done = 0;
    int e0 = 0, e1 = 0, e2 = 0, e3 = 0, e4 = 0, e5 = 0;
    int rn0 = 0, rn1 = 0, rn2 = 0, rn3 = 0, rn4 = 0, rn5 = 0;
    int lock_err = 0;
    realtime t0, t1, t2, t3, t4, t5;

    // Group order: 0 CPU, 1 PCI, 2 free PCI, 3 APIC, 4 REF, 5 48 MHz
    always @(posedge cpu_o[0])  begin e0++; t0 = $realtime; end
    always @(posedge pci_o[0])  begin e1++; t1 = $realtime; end
    always @(posedge free_o)    begin e2++; t2 = $realtime; end
    always @(posedge apic_o[0]) begin e3++; t3 = $realtime; end
    always @(posedge ref_o[0])  begin e4++; t4 = $realtime; end
    always @(posedge usb_o)     begin e5++; t5 = $realtime; end

    // R9: each high pulse must last one full source half period
    always @(negedge cpu_o[0])  if (rst_n && (($realtime - t0) < 9.99  || ($realtime - t0) > 10.01)) rn0++;
    always @(negedge pci_o[0])  if (rst_n && (($realtime - t1) < 14.99 || ($realtime - t1) > 15.01)) rn1++;
    always @(negedge free_o)    if (rst_n && (($realtime - t2) < 14.99 || ($realtime - t2) > 15.01)) rn2++;
    always @(negedge apic_o[0]) if (rst_n && (($realtime - t3) < 34.99 || ($realtime - t3) > 35.01)) rn3++;
    always @(negedge ref_o[0])  if (rst_n && (($realtime - t4) < 34.99 || ($realtime - t4) > 35.01)) rn4++;
    always @(negedge usb_o)     if (rst_n && (($realtime - t5) < 10.99 || ($realtime - t5) > 11.01)) rn5++;

    // R11: outputs in a group stay equal
    initial forever begin
        #3.3;
        if (!(cpu_o == '0 || cpu_o == '1)) lock_err++;
        if (!(pci_o == '0 || pci_o == '1)) lock_err++;
        if (!({apic_o, ref_o} == '0 || {apic_o, ref_o} == '1)) lock_err++;
    end

    function automatic int edges(int g);
        case (g)
            0: return e0;
            1: return e1;
            2: return e2;
            3: return e3;
            4: return e4;
            default: return e5;
        endcase
    endfunction

    function automatic real half_period(int g);
        case (g)
            0: return 10.0;
            1, 2: return 15.0;
            3, 4: return 35.0;
            default: return 11.0;
        endcase
    endfunction

    typedef struct {
        string             req;
        realtime           win;
        logic [5:0][15:0]  lo;
        logic [5:0][15:0]  hi;
    } item_t;

    item_t sb_q[$];

    // Monitor: pop an expectation, observe the window, compare
    initial begin
        item_t it;
        int base [6];
        forever begin
            wait (sb_q.size() != 0);
            it = sb_q.pop_front();
            for (int g = 0; g < 6; g++) base[g] = edges(g);
            #(it.win);
            for (int g = 0; g < 6; g++) begin
                int d;
                if (it.lo[g] == 16'd0 && it.hi[g] == ANY) continue;
                d = edges(g) - base[g];
                n_tests++;
                if (d < int'(it.lo[g]) || d > int'(it.hi[g])) begin
                    n_fail++;
                    $display("FAIL %s group %0d: actual %0d rising edges, expected %0d..%0d",
                             it.req, g, d, it.lo[g], it.hi[g]);
                end
            end
            n_done++;
        end
    end

    task automatic run_item(item_t it);
        int target;
        target = n_done + 1;
        sb_q.push_back(it);
        wait (n_done == target);
    endtask

    // Driver: run = group expected toggling, care = group checked
    task automatic expect_win(string req, realtime w, logic [5:0] run, logic [5:0] care);
        item_t it;
        it.req = req;
        it.win = w;
        for (int g = 0; g < 6; g++) begin
            int n;
            if (!care[g]) begin
                it.lo[g] = 16'd0; it.hi[g] = ANY;
            end else if (run[g]) begin
                n = int'(w / (2.0 * half_period(g)));
                it.lo[g] = 16'(n - 1); it.hi[g] = 16'(n + 1);
            end else begin
                it.lo[g] = 16'd0; it.hi[g] = 16'd0;
            end
        end
        run_item(it);
    endtask

    task automatic expect_lat(string req, realtime w, int grp, int lo, int hi);
        item_t it;
        it.req = req;
        it.win = w;
        for (int g = 0; g < 6; g++) begin
            it.lo[g] = 16'd0; it.hi[g] = ANY;
        end
        it.lo[grp] = 16'(lo);
        it.hi[grp] = 16'(hi);
        run_item(it);
    endtask

    localparam logic [5:0] ALL = 6'b111111;

    initial begin
        // R10: reset holds every output low
        #1 rst_n = 1'b0;
        expect_win("R10 reset", 150.0, 6'b000000, ALL);
        #49 rst_n = 1'b1;
        #300;
        // R10: no wake delay after reset
        expect_win("R10 start", 700.0, ALL, ALL);

        // R1: CPU stop latency, then silence; other groups unaffected
        @(posedge clk_cpu); #2 cpu_stop_n = 1'b0;
        expect_lat("R1 stop latency", 100.0, 0, 2, 3);
        expect_win("R1 held", 300.0, 6'b111110, ALL);

        // R2: CPU resume latency and full rate
        @(posedge clk_cpu); #2 cpu_stop_n = 1'b1;
        expect_lat("R2 resume latency", 100.0, 0, 2, 4);
        expect_win("R2 running", 400.0, ALL, ALL);

        // R3 and R5: PCI stop latency, silence, free PCI unaffected
        @(posedge clk_pci); #2 pci_stop_n = 1'b0;
        expect_lat("R3 stop latency", 150.0, 1, 2, 3);
        expect_win("R3 held", 300.0, 6'b111101, 6'b000011);
        expect_win("R5 free runs", 600.0, 6'b111101, 6'b000101);

        // R4: PCI resume
        @(posedge clk_pci); #2 pci_stop_n = 1'b1;
        expect_lat("R4 resume latency", 150.0, 1, 2, 4);
        expect_win("R4 running", 300.0, ALL, 6'b000110);

        // R6: power-down silences everything
        @(posedge clk_cpu); #2 pwr_dn_n = 1'b0;
        expect_lat("R6 cpu latency", 100.0, 0, 2, 3);
        #400;
        expect_win("R6 all low", 1400.0, 6'b000000, ALL);

        // R7: wake delay counted, then full rate
        pwr_dn_n = 1'b1;
        expect_win("R7 wake hold", 2000.0, 6'b000000, ALL);
        #1500;
        expect_win("R7 after wake", 700.0, ALL, ALL);

        // R8: power-down overrides, then a low CPU stop still governs
        cpu_stop_n = 1'b0;
        #200;
        pwr_dn_n = 1'b0;
        #600;
        expect_win("R8 pd dominates", 300.0, 6'b000000, ALL);
        pwr_dn_n = 1'b1;
        #3600;
        expect_win("R8 stop governs", 700.0, 6'b111110, ALL);
        cpu_stop_n = 1'b1;
        #200;
        expect_win("R8 stop released", 400.0, ALL, 6'b000001);

        // R9: pulse widths; R11: lockstep
        n_tests++;
        if (rn0 + rn1 + rn2 + rn3 + rn4 + rn5 != 0) begin
            n_fail++;
            $display("FAIL R9 short pulses: actual %0d, expected 0", rn0 + rn1 + rn2 + rn3 + rn4 + rn5);
        end
        n_tests++;
        if (lock_err != 0) begin
            n_fail++;
            $display("FAIL R11 group mismatch: actual %0d, expected 0", lock_err);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #200000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule